// File: doc/BRIEF.md
# Pulse-Swallowing Feedback Divider with Reference Divider

This block holds the two programmable counters of a frequency synthesizer: the loop divider that brings the oscillator clock down to the comparison rate, and the divider on the reference side. The loop divider chains a short prescaler and two counters. The prescaler divides by 6 or by 7, or by 12 or 14 when doubling is selected. A 6-bit main count sets how many prescaler cycles make up one output period. A 4-bit swallow count sets how many of those cycles use the longer modulus. With a swallow count of zero, every prescaler cycle uses the longer modulus.

Each output period produces a pulse one clock wide at its terminal count. New main, swallow and doubling settings take effect only where one output period ends and the next begins, so no shortened or stretched period is ever produced. The reference counter divides the same clock by its 7-bit setting plus one, and it also reloads only at its own terminal count. A swallow count larger than the main count is flagged, and the divider then runs as if the swallow count were zero.

Top module: `fbdiv_top`

## Requirements
- R1: While reset is asserted, and until the first terminal count after reset, `fb_pulse`, `ref_pulse` and `cfg_illegal` are all 0.
- R2: With swallow count A in 1..M and doubling off, the interval between consecutive `fb_pulse` assertions is 6·(M+1)+A clock cycles.
- R3: With A = 0 and doubling off, the interval between consecutive `fb_pulse` assertions is 7·(M+1) cycles.
- R4: With `dbl_in` = 1, the prescaler moduli become 12 and 14, so every interval of R2, R3 and R8 is doubled.
- R5: `fb_pulse` is high for exactly one clock cycle per output period.
- R6: The interval between consecutive `ref_pulse` assertions is R+1 cycles. R is the 7-bit `r_in` value sampled at the clock edge that produced the earlier pulse, so R = 0 gives a pulse on every cycle and R = 127 gives one every 128 cycles.
- R7: Main, swallow and doubling settings are sampled only at the clock edge that raises `fb_pulse`. A change between pulses leaves the period in progress at its old length.
- R8: When the loaded A exceeds the loaded M, `cfg_illegal` is 1 from the loading edge until the next load, and the interval is 7·(M+1) cycles (doubled under R4). Otherwise `cfg_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (the oscillator-side clock) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_in | input | 6 | Main count; the output period spans M+1 prescaler cycles |
| a_in | input | 4 | Swallow count; the number of long prescaler cycles per period |
| dbl_in | input | 1 | 1 selects the 12/14 prescaler instead of 6/7 |
| r_in | input | 7 | Reference divide setting; the modulus is the value plus 1 |
| fb_pulse | output | 1 | One-cycle pulse at each loop-divider terminal count |
| ref_pulse | output | 1 | One-cycle pulse at each reference-divider terminal count |
| cfg_illegal | output | 1 | 1 while the loaded swallow count exceeds the loaded main count |

## Verification
The loop divider is driven through a run of settings, and each one is aimed at a different fault. A nonzero swallow count with a small main count shows whether the long cycles are counted on the correct number of prescaler wraps. A zero swallow count with M = 0 gives the shortest period of seven cycles. The largest main and swallow counts, with and without doubling, expose counters that wrap or are truncated. An over-range swallow count shows whether the flag appears and whether the period falls back to all-long cycles. Every setting change is applied just after a pulse, so the period already in progress must keep its old length. The reference divide value moves between 3, 0 and 127 to cover an ordinary modulus and both extremes.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Length of one prescaler cycle: short is the base modulus, long adds one.
  typedef enum logic {
    PS_SHORT = 1'b0,
    PS_LONG  = 1'b1
  } ps_len_e;

endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
#(
  parameter int PRE_BASE = 6,
  parameter int PC_W     = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ps_len_e reload_len,
  input  logic    reload_dbl,
  output logic    uf
);

  localparam logic [PC_W-1:0] PC_MAX = PC_W'(2 * (PRE_BASE + 1) - 1);

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] mod_w;
  logic [PC_W-1:0] reload_val;

  // Modulus of the next prescaler cycle.
  always_comb begin
    mod_w = PC_W'(PRE_BASE) + ((reload_len == PS_LONG) ? PC_W'(1) : PC_W'(0));
    if (reload_dbl) begin
      mod_w = mod_w << 1;
    end
    reload_val = mod_w - PC_W'(1);
  end

  always_comb begin
    uf   = (pc_q == '0);
    pc_d = uf ? reload_val : (pc_q - PC_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  // R2: the prescaler count never leaves the doubled long-modulus range.
  p_pc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_MAX);

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
  import fbdiv_pkg::*;
#(
  parameter int M_W = 6,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           uf,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           a_zero,
  output logic           last,
  output ps_len_e        next_len
);

  logic [M_W-1:0] mc_q, mc_d;
  logic [A_W-1:0] ac_q, ac_d;
  logic [A_W-1:0] ac_dec;

  always_comb begin
    ac_dec = (ac_q != '0) ? (ac_q - A_W'(1)) : '0;
    last   = (mc_q == '0);
  end

  // A new period always opens with a long cycle: either every cycle is
  // long (A = 0) or at least one long cycle is owed (A >= 1).
  always_comb begin
    if (load) begin
      next_len = PS_LONG;
    end else if (a_zero || (ac_dec != '0)) begin
      next_len = PS_LONG;
    end else begin
      next_len = PS_SHORT;
    end
  end

  always_comb begin
    mc_d = mc_q;
    ac_d = ac_q;
    if (load) begin
      mc_d = m_in;
      ac_d = a_in;
    end else if (uf) begin
      mc_d = mc_q - M_W'(1);
      ac_d = ac_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
      ac_q <= '0;
    end else if (load || uf) begin
      mc_q <= mc_d;
      ac_q <= ac_d;
    end
  end

  // R8: within a period the owed long-cycle count only falls.
  p_ac_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ac_q <= $past(ac_q));

endmodule

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg #(
  parameter int M_W = 6,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           dbl_in,
  output logic           dbl_act,
  output logic           a_zero,
  output logic           illegal
);

  localparam int CW = (M_W > A_W) ? M_W : A_W;

  logic dbl_q, dbl_d;
  logic az_q, az_d;
  logic ill_q, ill_d;

  always_comb begin
    dbl_d = dbl_q;
    az_d  = az_q;
    ill_d = ill_q;
    if (load) begin
      dbl_d = dbl_in;
      az_d  = (a_in == '0);
      ill_d = (CW'(a_in) > CW'(m_in));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbl_q <= 1'b0;
      az_q  <= 1'b0;
      ill_q <= 1'b0;
    end else if (load) begin
      dbl_q <= dbl_d;
      az_q  <= az_d;
      ill_q <= ill_d;
    end
  end

  assign dbl_act = dbl_q;
  assign a_zero  = az_q;
  assign illegal = ill_q;

  // R7: the captured settings stay frozen between period boundaries.
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({dbl_q, az_q, ill_q}));

endmodule

// File: rtl/fbdiv_refdiv.sv
module fbdiv_refdiv #(
  parameter int R_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] r_in,
  output logic           ref_pulse
);

  logic [R_W-1:0] rc_q, rc_d;
  logic           first_q, first_d;
  logic           pulse_q, pulse_d;
  logic           term;

  always_comb begin
    term    = (rc_q == '0);
    rc_d    = term ? r_in : (rc_q - R_W'(1));
    pulse_d = term & ~first_q;
    first_d = term ? 1'b0 : first_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q    <= '0;
      first_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      rc_q    <= rc_d;
      first_q <= first_d;
      pulse_q <= pulse_d;
    end
  end

  assign ref_pulse = pulse_q;

  // R6: each reference pulse coincides with a reload from the setting.
  p_ref_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> rc_q == $past(r_in));

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int M_W      = 6,
  parameter int A_W      = 4,
  parameter int R_W      = 7,
  parameter int PRE_BASE = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           dbl_in,
  input  logic [R_W-1:0] r_in,
  output logic           fb_pulse,
  output logic           ref_pulse,
  output logic           cfg_illegal
);

  localparam int PC_W = $clog2(2 * (PRE_BASE + 1));

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rs_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int = rs_q[1];

  logic    uf;
  logic    last;
  logic    load;
  ps_len_e next_len;
  logic    dbl_act;
  logic    a_zero;
  logic    reload_dbl;

  assign load       = uf & last;
  assign reload_dbl = load ? dbl_in : dbl_act;

  fbdiv_prescaler #(
    .PRE_BASE (PRE_BASE),
    .PC_W     (PC_W)
  ) u_pre (
    .clk        (clk),
    .rst_n      (rst_int),
    .reload_len (next_len),
    .reload_dbl (reload_dbl),
    .uf         (uf)
  );

  fbdiv_swallow #(
    .M_W (M_W),
    .A_W (A_W)
  ) u_swl (
    .clk      (clk),
    .rst_n    (rst_int),
    .uf       (uf),
    .load     (load),
    .m_in     (m_in),
    .a_in     (a_in),
    .a_zero   (a_zero),
    .last     (last),
    .next_len (next_len)
  );

  fbdiv_cfg #(
    .M_W (M_W),
    .A_W (A_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int),
    .load    (load),
    .m_in    (m_in),
    .a_in    (a_in),
    .dbl_in  (dbl_in),
    .dbl_act (dbl_act),
    .a_zero  (a_zero),
    .illegal (cfg_illegal)
  );

  fbdiv_refdiv #(
    .R_W (R_W)
  ) u_ref (
    .clk       (clk),
    .rst_n     (rst_int),
    .r_in      (r_in),
    .ref_pulse (ref_pulse)
  );

  // Output pulse register; the first terminal count after reset only
  // captures the settings and raises no pulse.
  logic fb_q, fb_d;
  logic first_q, first_d;

  always_comb begin
    fb_d    = load & ~first_q;
    first_d = load ? 1'b0 : first_q;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      fb_q    <= 1'b0;
      first_q <= 1'b1;
    end else begin
      fb_q    <= fb_d;
      first_q <= first_d;
    end
  end

  assign fb_pulse = fb_q;

  // R5: a feedback pulse never lasts into the following cycle.
  p_fb_single_r5: assert property (@(posedge clk) disable iff (!rst_int)
    fb_q |=> !fb_q);

  // R1: nothing is flagged before the first settings are captured.
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int)
    first_q |-> !cfg_illegal && !fb_q);

endmodule

// File: tb/sim_fbdiv_top.sv
module sim_fbdiv_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] m_in;
  logic [3:0] a_in;
  logic       dbl_in;
  logic [6:0] r_in;
  logic       fb_pulse, ref_pulse, cfg_illegal;

  always #4 clk = ~clk;

  fbdiv_top u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .m_in        (m_in),
    .a_in        (a_in),
    .dbl_in      (dbl_in),
    .r_in        (r_in),
    .fb_pulse    (fb_pulse),
    .ref_pulse   (ref_pulse),
    .cfg_illegal (cfg_illegal)
  );

  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  string tag_q[$];
  int    prev_n;
  logic  mon_on = 1'b0;
  logic  done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int calc_n(input int m, input int a, input bit d);
    int k, sw, n;
    k  = m + 1;
    sw = (a == 0 || a > m) ? k : a;
    n  = 6 * k + sw;
    return d ? 2 * n : n;
  endfunction

  // Monitor: measures pulse intervals and compares them with the scoreboard.
  int   cyc = 0;
  int   fb_last = 0, ref_last = 0, ref_exp = 0;
  logic fb_seen = 1'b0, ref_seen = 1'b0, fb_prev = 1'b0;
  logic [6:0] r_edge;

  always @(posedge clk) r_edge <= r_in;

  always @(negedge clk) begin
    cyc++;
    if (mon_on && !done) begin
      if (fb_pulse) begin
        if (fb_prev) check(1'b0, "R5", 2, 1);
        if (fb_seen) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected pulse", cyc - fb_last, -1);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check((cyc - fb_last) == e, t, cyc - fb_last, e);
          end
        end
        fb_seen = 1'b1;
        fb_last = cyc;
      end
      fb_prev = fb_pulse;
      if (ref_pulse) begin
        if (ref_seen) check((cyc - ref_last) == ref_exp, "R6", cyc - ref_last, ref_exp);
        ref_exp  = int'(r_edge) + 1;
        ref_seen = 1'b1;
        ref_last = cyc;
      end
    end
  end

  task automatic wait_fb();
    do @(negedge clk); while (!fb_pulse);
  endtask

  // Driver: changes settings just after a pulse and pushes expected intervals.
  task automatic apply(input int m, input int a, input bit d, input int r,
                       input int cnt, input string tag);
    int n;
    wait_fb();
    m_in   = 6'(m);
    a_in   = 4'(a);
    dbl_in = d;
    r_in   = 7'(r);
    exp_q.push_back(prev_n);
    tag_q.push_back("R7 old period kept");
    n = calc_n(m, a, d);
    for (int i = 0; i < cnt; i++) begin
      exp_q.push_back(n);
      tag_q.push_back(tag);
    end
    prev_n = n;
    for (int i = 0; i < cnt; i++) begin
      wait_fb();
      if (i == 0) check(cfg_illegal == (a > m), "R8 flag", int'(cfg_illegal), int'(a > m));
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_in   = 6'd5;
    a_in   = 4'd0;
    dbl_in = 1'b0;
    r_in   = 7'd3;
    prev_n = calc_n(5, 0, 1'b0);
    repeat (3) @(negedge clk);
    check(fb_pulse == 1'b0, "R1 fb", int'(fb_pulse), 0);
    check(ref_pulse == 1'b0, "R1 ref", int'(ref_pulse), 0);
    check(cfg_illegal == 1'b0, "R1 flag", int'(cfg_illegal), 0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
    check(fb_pulse == 1'b0 && cfg_illegal == 1'b0, "R1 after release", int'(fb_pulse), 0);

    apply(5, 3, 1'b0, 0, 3, "R2 m5 a3");
    apply(0, 0, 1'b0, 0, 3, "R3 m0 a0");
    apply(63, 15, 1'b0, 3, 2, "R2 m63 a15");
    apply(10, 0, 1'b1, 3, 2, "R4 R3 doubled");
    apply(5, 9, 1'b0, 127, 3, "R8 a over m");
    apply(3, 3, 1'b1, 127, 2, "R4 R2 doubled");
    apply(2, 7, 1'b1, 5, 2, "R8 R4 doubled over");
    apply(63, 0, 1'b1, 5, 1, "R4 R3 max");
    apply(1, 1, 1'b0, 5, 3, "R2 m1 a1");
    wait_fb();
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule